// File: doc/BRIEF.md
# Dual-Mode Serial FSK Character Port

This block sits behind an FSK demodulator and hands the recovered asynchronous bit stream to a host microcontroller. A mode input picks one of two presentations. In pass-through mode the demodulated line is routed straight to the data output, and the host does its own bit timing. In buffered mode the block frames each character itself. It drops the start bit, keeps the eight data bits and the stop bit, and pulls an active-low ready line when a character is complete. The host then clocks the bits out with its own pulses on a data-clock input.

The receiver oversamples the line 16 times per bit, using a tick divided down from the system clock. Each data-clock pulse from the host advances the output by one bit. The output changes on the falling edge, so the host samples on the rising edge. After the eight data bits, a ninth pulse exposes the stop bit, which lets the host detect a framing error. When mode-select is high and both other control bits are low, the block is powered down: it ignores the line and holds its outputs idle.

Top module: `fsk_serial_port`

## Requirements
- R1: With `mode_buf` low the block is in pass-through mode. With `mode_buf` high and at least one of `ctl_a`/`ctl_b` high it is in buffered mode.
- R2: In pass-through mode `data_out` equals `rx_in` in the same cycle, `host_clk` has no effect, and `ready_n` stays high.
- R3: A character is one low start bit, eight data bits sent least-significant bit first, and one stop bit. Each bit lasts 16 oversampling ticks and is sampled at mid-bit. The start bit is discarded and the eight data bits plus the stop bit are captured.
- R4: In buffered mode `ready_n` goes low within a few cycles after the stop bit is sampled.
- R5: When `ready_n` goes low, `data_out` carries data bit 0. Each falling edge of `host_clk` advances `data_out` to the next bit, so the host reads the data bits LSB first on eight rising edges.
- R6: After the eighth falling edge `data_out` carries the captured stop bit, which is read on the ninth rising edge. After the ninth falling edge `data_out` stays high.
- R7: `ready_n` returns high on the first rising edge of `host_clk` or when the next start bit is confirmed, whichever comes first.
- R8: With `mode_buf` high and `ctl_a`, `ctl_b` both low the block is powered down. `data_out` and `ready_n` are held high, and characters arriving on `rx_in` are not captured.
- R9: A falling edge on `rx_in` whose line is high again at mid-bit is rejected, and no character results. The receiver still accepts the next valid character.
- R10: If a new character completes before the host has shifted out the previous one, the new character replaces it and shifting restarts at data bit 0.
- R11: After reset in buffered mode, `ready_n` and `data_out` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_buf | input | 1 | Mode select: 0 pass-through, 1 buffered |
| ctl_a | input | 1 | Control bit; with ctl_b low and mode_buf high selects power-down |
| ctl_b | input | 1 | Control bit; with ctl_a low and mode_buf high selects power-down |
| rx_in | input | 1 | Demodulated asynchronous FSK bit stream, idle high |
| host_clk | input | 1 | Host-driven data clock for shifting out a character |
| data_out | output | 1 | Serial data to the host |
| ready_n | output | 1 | Active-low character-ready indication |

## Verification
Suppose the framer's bit counter or tick phase goes wrong. The host would then see a shifted or corrupted byte on the very first character, or the ready line would fall at the wrong time. The output pointer fails differently: a bad pointer shows up as a wrong bit within one host-clock pulse, and the stop-bit and idle-high checks catch an off-by-one at the end of the shift. A stale ready flag stays low after the first host rising edge or after a new start bit, and a power-down decode error shows up at once as a non-idle output.

// File: rtl/fsk_port_pkg.sv
package fsk_port_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
    parameter int DIV = 6510
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == W'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + W'(1);
        if (clr) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fsk_sync.sv
module fsk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic q_prev
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-1:0], din};
        q      = sh_q[STAGES-1];
        q_prev = sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {(STAGES+1){RST_VAL}};
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/fsk_framer.sv
module fsk_framer
    import fsk_port_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int NDATA = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             rx,
    input  logic             rx_prev,
    output logic             start_ok,
    output logic             frame_done,
    output logic [NDATA:0]   frame
);
    localparam int TW  = $clog2(OSR);
    localparam int BW  = $clog2(NDATA + 1);
    localparam int MID = OSR / 2 - 1;
    localparam int LST = OSR - 1;

    typedef struct packed {
        rx_state_e        st;
        logic [TW-1:0]    tcnt;
        logic [BW-1:0]    nbit;
        logic [NDATA-1:0] data;
    } fr_regs_t;

    fr_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        start_ok   = 1'b0;
        frame_done = 1'b0;
        frame      = {rx, r_q.data};
        if (!en) begin
            r_d.st   = RX_IDLE;
            r_d.tcnt = '0;
            r_d.nbit = '0;
        end else begin
            case (r_q.st)
                RX_IDLE: begin
                    if (rx_prev && !rx) begin
                        r_d.st   = RX_START;
                        r_d.tcnt = '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (r_q.tcnt == TW'(MID)) begin
                            r_d.tcnt = '0;
                            r_d.nbit = '0;
                            if (!rx) begin
                                r_d.st   = RX_DATA;
                                start_ok = 1'b1;
                            end else begin
                                r_d.st = RX_IDLE;
                            end
                        end else begin
                            r_d.tcnt = r_q.tcnt + TW'(1);
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        r_d.tcnt = r_q.tcnt + TW'(1);
                        if (r_q.tcnt == TW'(LST)) begin
                            r_d.data = {rx, r_q.data[NDATA-1:1]};
                            r_d.nbit = r_q.nbit + BW'(1);
                            if (r_q.nbit == BW'(NDATA - 1)) r_d.st = RX_STOP;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        r_d.tcnt = r_q.tcnt + TW'(1);
                        if (r_q.tcnt == TW'(LST)) begin
                            frame_done = 1'b1;
                            r_d.st     = RX_IDLE;
                        end
                    end
                end
                default: r_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= RX_IDLE;
            r_q.tcnt <= '0;
            r_q.nbit <= '0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/fsk_serial_port.sv
module fsk_serial_port #(
    parameter int CLK_PER_TICK = 6510,
    parameter int OSR          = 16,
    parameter int NDATA        = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_buf,
    input  logic ctl_a,
    input  logic ctl_b,
    input  logic rx_in,
    input  logic host_clk,
    output logic data_out,
    output logic ready_n
);
    localparam int PW = $clog2(NDATA + 2);

    typedef struct packed {
        logic [NDATA:0]  sbuf;
        logic [PW-1:0]   pos;
        logic            out;
        logic            rdy_n;
    } port_regs_t;

    port_regs_t p_d, p_q;

    logic pdown, en, tick;
    logic rx_s, rx_s_prev, hc_s, hc_s_prev, hc_rise, hc_fall;
    logic start_ok, frame_done;
    logic [NDATA:0] frame;
    logic [PW-1:0]  nxt;

    assign pdown   = mode_buf & ~ctl_a & ~ctl_b;
    assign en      = mode_buf & ~pdown;
    assign hc_rise = hc_s & ~hc_s_prev;
    assign hc_fall = ~hc_s & hc_s_prev;
    assign nxt     = p_q.pos + PW'(1);

    fsk_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(~en), .tick(tick)
    );

    fsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .q(rx_s), .q_prev(rx_s_prev)
    );

    fsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hc_sync (
        .clk(clk), .rst_n(rst_n), .din(host_clk), .q(hc_s), .q_prev(hc_s_prev)
    );

    fsk_framer #(.OSR(OSR), .NDATA(NDATA)) u_framer (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .rx(rx_s), .rx_prev(rx_s_prev),
        .start_ok(start_ok), .frame_done(frame_done), .frame(frame)
    );

    always_comb begin
        p_d = p_q;
        if (!en) begin
            p_d.sbuf  = '1;
            p_d.pos   = PW'(NDATA + 1);
            p_d.out   = 1'b1;
            p_d.rdy_n = 1'b1;
        end else if (frame_done) begin
            p_d.sbuf  = frame;
            p_d.pos   = '0;
            p_d.out   = frame[0];
            p_d.rdy_n = 1'b0;
        end else begin
            if (hc_rise || start_ok) p_d.rdy_n = 1'b1;
            if (hc_fall && p_q.pos <= PW'(NDATA)) begin
                p_d.pos = nxt;
                p_d.out = (nxt <= PW'(NDATA)) ? p_q.sbuf[nxt] : 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.sbuf  <= '1;
            p_q.pos   <= PW'(NDATA + 1);
            p_q.out   <= 1'b1;
            p_q.rdy_n <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    assign data_out = pdown ? 1'b1 : (mode_buf ? p_q.out : rx_in);
    assign ready_n  = ~en | p_q.rdy_n;
endmodule

// File: rtl/fsk_serial_port_chk.sv
module fsk_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_buf,
    input logic en,
    input logic pdown,
    input logic hc_rise,
    input logic hc_fall,
    input logic frame_done,
    input logic data_out,
    input logic ready_n
);
    assert_pdown_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pdown |-> (data_out && ready_n));

    assert_passthru_noready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_buf |-> ready_n);

    assert_ready_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && frame_done) |=> (!en || !ready_n));

    assert_ready_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hc_rise && !frame_done) |=> ready_n);

    assert_shift_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hc_fall && !frame_done) |=> (!en || $stable(data_out)));
endmodule

bind fsk_serial_port fsk_serial_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .en(en), .pdown(pdown),
    .hc_rise(hc_rise), .hc_fall(hc_fall), .frame_done(frame_done),
    .data_out(data_out), .ready_n(ready_n)
);

// File: tb/fsk_serial_port_test.sv
module fsk_serial_port_test;
    localparam int CPT = 4;
    localparam int BIT = 16 * CPT;
    localparam int NV  = 5;
    localparam logic [8:0] VEC [NV] = '{9'h1A5, 9'h100, 9'h1FF, 9'h0C3, 9'h15A};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_buf = 1'b1, ctl_a = 1'b1, ctl_b = 1'b0;
    logic rx_in = 1'b1, host_clk = 1'b0;
    logic data_out, ready_n;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    fsk_serial_port #(.CLK_PER_TICK(CPT)) uut (
        .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .rx_in(rx_in), .host_clk(host_clk), .data_out(data_out), .ready_n(ready_n)
    );

    always #4 clk = ~clk;

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input logic [8:0] v);
        rx_in = 1'b0; cyc(BIT);
        for (int i = 0; i < 9; i++) begin
            rx_in = v[i]; cyc(BIT);
        end
        rx_in = 1'b1; cyc(6);
    endtask

    task automatic pulse();
        host_clk = 1'b1; cyc(8);
        host_clk = 1'b0; cyc(8);
    endtask

    task automatic shift_check(input logic [8:0] v, input string req);
        for (int k = 0; k < 9; k++) begin
            check(data_out, v[k], (k == 8) ? "R6" : req, $sformatf("bit %0d", k));
            pulse();
            if (k == 0) check(ready_n, 1'b1, "R7", "ready after first rise");
        end
        check(data_out, 1'b1, "R6", "idle after ninth pulse");
    endtask

    initial begin
        cyc(3);
        check(ready_n, 1'b1, "R11", "reset ready_n");
        check(data_out, 1'b1, "R11", "reset data_out");
        rst_n = 1'b1;
        cyc(4);
        check(ready_n, 1'b1, "R11", "ready_n after release");

        // table walk: R1 buffered mode, R3 framing, R4 ready, R5/R6 shift-out
        for (int v = 0; v < NV; v++) begin
            send_char(VEC[v]);
            check(ready_n, 1'b0, "R4", $sformatf("ready vec %0d", v));
            shift_check(VEC[v], "R3");
        end

        // R2 pass-through: follows rx_in, host_clk ignored (R1 mode low)
        mode_buf = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rx_in = i[0]; host_clk = i[1];
            cyc(3);
            check(data_out, rx_in, "R2", "pass-through follows line");
            check(ready_n, 1'b1, "R2", "pass-through ready_n");
        end
        host_clk = 1'b0; rx_in = 1'b1;
        cyc(4);

        // R8 power-down
        mode_buf = 1'b1; ctl_a = 1'b0; ctl_b = 1'b0;
        cyc(2);
        rx_in = 1'b0; cyc(3);
        check(data_out, 1'b1, "R8", "powered-down output idle");
        rx_in = 1'b1; cyc(4);
        send_char(9'h133);
        check(ready_n, 1'b1, "R8", "no capture in power-down");
        check(data_out, 1'b1, "R8", "output idle after char");
        ctl_b = 1'b1;
        cyc(4);
        check(ready_n, 1'b1, "R8", "no stale ready on wake");
        send_char(9'h1E1);
        check(ready_n, 1'b0, "R1", "buffered via ctl_b");
        shift_check(9'h1E1, "R5");

        // R9 short glitch rejected, then a valid character
        rx_in = 1'b0; cyc(3 * CPT);
        rx_in = 1'b1; cyc(12 * BIT);
        check(ready_n, 1'b1, "R9", "glitch gives no char");
        send_char(9'h14E);
        check(ready_n, 1'b0, "R9", "valid char after glitch");
        shift_check(9'h14E, "R9");

        // R7 next start clears ready, R10 overwrite
        send_char(9'h1F0);
        check(ready_n, 1'b0, "R10", "first char ready");
        fork
            send_char(9'h10F);
            begin
                cyc(2 * BIT);
                check(ready_n, 1'b1, "R7", "cleared by next start");
            end
        join
        check(ready_n, 1'b0, "R10", "second char ready");
        pulse(); pulse();
        send_char(9'h1C6);
        check(ready_n, 1'b0, "R10", "third char ready mid-shift");
        shift_check(9'h1C6, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule